// File: doc/BRIEF.md
# Time-Slice Bus Arbiter

This block arbitrates a shared bus among a small set of initiators, each with its own request and grant line. The current owner keeps the grant for a programmable minimum number of bus clocks, called the slice. During the slice the owner can run many short back-to-back transactions without losing the bus. When the slice has run out, the grant moves to another requesting initiator at the next transaction boundary. If nobody else is asking, the owner keeps the bus. This gives fair bandwidth to initiators that cannot use long bursts.

Software sets the slice through an 8-bit configuration register. The upper five bits give the slice length in units of eight clocks. The lowest three bits are reserved. Writing zero turns the slice off. The arbiter then changes owner at every idle boundary where another initiator is requesting.

The controller is a three-state machine:
- **VACANT**: no owner. This is the state after reset.
- **SLICE**: the owner holds the bus and the slice counter is running.
- **OPEN**: the slice has expired, or the slice is disabled.

The transitions are:
- *first-grant*: VACANT to SLICE or OPEN, when the bus is idle and any request is pending.
- *slice-end*: SLICE to OPEN, when the count reaches its last cycle and no hand-over happens.
- *hand-over*: from SLICE on its last count cycle, or from OPEN, to SLICE or OPEN, when the bus is idle and another initiator requests.
- *hold*: every other case, in which the state does not change.

Top module: `slice_arbiter`

## Requirements
- R1: After reset no grant is asserted and the configuration register reads 00h.
- R2: A register write stores bits 7:3 of the written value. Bits 2:0 always read as zero and writes to them have no effect: writing FFh reads back F8h, and writing 07h reads back 00h.
- R3: At most one grant line is high at any time. Once a grant has been given, some grant line stays high from then on, because the last owner is held.
- R4: From the no-owner state, when the bus is idle the grant goes to the lowest-numbered requesting initiator, with index 0 as the lowest.
- R5: With a non-zero register value L, the new owner holds the grant for at least L consecutive clocks, counting the clock in which it was granted, even while others are requesting. For example, 08h gives 8 clocks and 18h gives 24 clocks.
- R6: On the last clock of the slice, or on any later clock, the grant moves on the first idle clock on which another initiator is requesting.
- R7: The grant lines change only on a clock in which the bus-idle input was sampled high.
- R8: The next owner is the first requesting initiator found going upward from the current owner plus one and wrapping around. Initiators that are not requesting are skipped, and the current owner is not considered.
- R9: After the slice has expired with no other requester, the owner keeps its grant even if it drops its own request.
- R10: With the register at zero, the grant moves at every idle clock on which another initiator requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N_REQ | Request line from each initiator |
| bus_idle | input | 1 | High on clocks at a transaction boundary, when the bus is idle |
| cfg_wr_en | input | 1 | Write strobe for the slice register |
| cfg_wr_data | input | 8 | Write data for the slice register |
| cfg_rd_data | output | 8 | Current slice register contents |
| gnt | output | N_REQ | One-hot grant lines |

## Verification
The bench builds the arbiter with its defaults: four initiators and an 8-bit register with three reserved bits. Four initiators are enough to reach round-robin wrap-around from the highest index, skipping of idle initiators, and the case where only the owner is requesting. The 8-clock granularity means both an 8-clock slice and a 24-clock slice can be timed edge by edge within a short run. The disabled setting and the reserved-bit masking are reached with single register writes.

// File: rtl/tsarb_pkg.sv
package tsarb_pkg;
    typedef enum logic [1:0] {
        ARB_VACANT = 2'd0,
        ARB_SLICE  = 2'd1,
        ARB_OPEN   = 2'd2
    } arb_state_e;
endpackage

// File: rtl/tsarb_cfg_reg.sv
module tsarb_cfg_reg #(
    parameter int CFG_W = 8,
    parameter int RSV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    output logic             slice_off
);
    logic [CFG_W-RSV_W-1:0] field_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (wr_en) begin
            field_q <= wr_data[CFG_W-1:RSV_W];
        end
    end

    assign rd_data   = {field_q, {RSV_W{1'b0}}};
    assign slice_off = (field_q == '0);
endmodule

// File: rtl/tsarb_slice_cnt.sv
module tsarb_slice_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/tsarb_rr_pick.sv
module tsarb_rr_pick #(
    parameter int N_REQ = 4,
    localparam int IDX_W = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] req,
    input  logic [IDX_W-1:0] ptr,
    input  logic             incl_ptr,
    output logic             valid,
    output logic [IDX_W-1:0] pick
);
    always_comb begin
        valid = 1'b0;
        pick  = ptr;
        for (int k = 1; k <= N_REQ; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N_REQ;
            if (!valid && req[idx] && (k < N_REQ || incl_ptr)) begin
                valid = 1'b1;
                pick  = IDX_W'(idx);
            end
        end
    end
endmodule

// File: rtl/slice_arbiter.sv
module slice_arbiter
    import tsarb_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int CFG_W = 8,
    parameter int RSV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    input  logic             bus_idle,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    output logic [CFG_W-1:0] cfg_rd_data,
    output logic [N_REQ-1:0] gnt
);
    localparam int IDX_W = $clog2(N_REQ);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_REQ - 1);

    arb_state_e       state, state_n;
    logic [IDX_W-1:0] owner, owner_n;
    logic [CFG_W-1:0] slice_cnt;
    logic             slice_off;
    logic             pk_valid;
    logic [IDX_W-1:0] pk_idx;
    logic             cnt_load, cnt_dec;

    tsarb_cfg_reg #(.CFG_W(CFG_W), .RSV_W(RSV_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_data  (cfg_wr_data),
        .rd_data  (cfg_rd_data),
        .slice_off(slice_off)
    );

    tsarb_slice_cnt #(.CNT_W(CFG_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cfg_rd_data),
        .dec     (cnt_dec),
        .cnt     (slice_cnt)
    );

    tsarb_rr_pick #(.N_REQ(N_REQ)) u_pick (
        .req     (req),
        .ptr     (owner),
        .incl_ptr(state == ARB_VACANT),
        .valid   (pk_valid),
        .pick    (pk_idx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ARB_VACANT;
            owner <= LAST_IDX;
        end else begin
            state <= state_n;
            owner <= owner_n;
        end
    end

    // Next-state logic
    always_comb begin
        state_n  = state;
        owner_n  = owner;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state)
            ARB_VACANT, ARB_OPEN: begin
                if (bus_idle && pk_valid) begin
                    owner_n  = pk_idx;
                    cnt_load = 1'b1;
                    state_n  = slice_off ? ARB_OPEN : ARB_SLICE;
                end
            end
            ARB_SLICE: begin
                cnt_dec = 1'b1;
                if (slice_cnt <= CFG_W'(1)) begin
                    if (bus_idle && pk_valid) begin
                        owner_n  = pk_idx;
                        cnt_load = 1'b1;
                        state_n  = slice_off ? ARB_OPEN : ARB_SLICE;
                    end else begin
                        state_n = ARB_OPEN;
                    end
                end
            end
            default: state_n = ARB_VACANT;
        endcase
    end

    // Output decode
    always_comb begin
        gnt = '0;
        if (state != ARB_VACANT) begin
            gnt[owner] = 1'b1;
        end
    end
endmodule

// File: rtl/slice_arbiter_chk.sv
module slice_arbiter_chk
    import tsarb_pkg::*;
#(
    parameter int N_REQ = 4,
    parameter int CFG_W = 8,
    parameter int RSV_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_idle,
    input logic [N_REQ-1:0] gnt,
    input logic [CFG_W-1:0] cfg_rd_data,
    input arb_state_e       state,
    input logic [CFG_W-1:0] slice_cnt
);
    // R3
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3
    gnt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |=> (|gnt));

    // R7
    gnt_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != $past(gnt)) |-> $past(bus_idle));

    // R2
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[RSV_W-1:0] == '0);

    // R5
    slice_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_SLICE && slice_cnt > CFG_W'(1)) |=> $stable(gnt));
endmodule

bind slice_arbiter slice_arbiter_chk #(.N_REQ(N_REQ), .CFG_W(CFG_W), .RSV_W(RSV_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_idle   (bus_idle),
    .gnt        (gnt),
    .cfg_rd_data(cfg_rd_data),
    .state      (state),
    .slice_cnt  (slice_cnt)
);

// File: tb/tb_slice_arbiter.sv
`timescale 1ns/1ps
module tb_slice_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       bus_idle = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic [3:0] gnt;

    int checks = 0;
    int fails  = 0;
    logic [3:0] exp_g[$];
    logic [7:0] exp_r[$];
    string      exp_t[$];

    always #5 clk = ~clk;

    slice_arbiter dut (
        .clk(clk), .rst_n(rst_n), .req(req), .bus_idle(bus_idle),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .gnt(gnt)
    );

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Driver: drive one clock of stimulus and queue the result expected after that edge
    task automatic step(input logic [3:0] r, input logic idl, input logic we,
                        input logic [7:0] wd, input logic [3:0] eg,
                        input logic [7:0] er, input string tag);
        @(negedge clk);
        req = r; bus_idle = idl; cfg_wr_en = we; cfg_wr_data = wd;
        exp_g.push_back(eg); exp_r.push_back(er); exp_t.push_back(tag);
    endtask

    // Monitor: compare after each active edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_g.size() > 0) begin
                logic [3:0] eg;
                logic [7:0] er;
                string      t;
                eg = exp_g.pop_front(); er = exp_r.pop_front(); t = exp_t.pop_front();
                checks++;
                if (gnt !== eg || cfg_rd_data !== er) begin
                    fails++;
                    $display("FAIL %s gnt=%b rd=%h expected gnt=%b rd=%h", t, gnt, cfg_rd_data, eg, er);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (gnt !== 4'b0000 || cfg_rd_data !== 8'h00) begin
            fails++;
            $display("FAIL R1 gnt=%b rd=%h expected gnt=0000 rd=00", gnt, cfg_rd_data);
        end
        rst_n = 1'b1;
        step(4'b0000, 1'b1, 1'b0, 8'h00, 4'b0000, 8'h00, "R1");
        step(4'b0000, 1'b1, 1'b1, 8'hFF, 4'b0000, 8'hF8, "R2");
        step(4'b0000, 1'b1, 1'b1, 8'h0F, 4'b0000, 8'h08, "R2");
        // R7: no grant while bus busy; R4: lowest requester wins
        step(4'b0110, 1'b0, 1'b0, 8'h00, 4'b0000, 8'h08, "R7");
        step(4'b0110, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h08, "R4");
        for (int i = 0; i < 7; i++) step(4'b1111, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h08, "R5");
        step(4'b1111, 1'b1, 1'b0, 8'h00, 4'b0100, 8'h08, "R6");
        // owner 2: slice expires while bus busy
        for (int i = 0; i < 7; i++) step(4'b1011, 1'b1, 1'b0, 8'h00, 4'b0100, 8'h08, "R5");
        step(4'b1011, 1'b0, 1'b0, 8'h00, 4'b0100, 8'h08, "R7");
        step(4'b1011, 1'b0, 1'b0, 8'h00, 4'b0100, 8'h08, "R7");
        step(4'b1011, 1'b1, 1'b0, 8'h00, 4'b1000, 8'h08, "R8");
        // owner 3: wrap and skip idle initiator 0
        for (int i = 0; i < 7; i++) step(4'b0010, 1'b1, 1'b0, 8'h00, 4'b1000, 8'h08, "R5");
        step(4'b0010, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h08, "R8");
        // owner 1: nobody requests, grant kept
        for (int i = 0; i < 11; i++) step(4'b0000, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h08, "R9");
        step(4'b0010, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h08, "R9");
        // disabled slice
        step(4'b0010, 1'b1, 1'b1, 8'h00, 4'b0010, 8'h00, "R10");
        step(4'b1111, 1'b1, 1'b0, 8'h00, 4'b0100, 8'h00, "R10");
        step(4'b1111, 1'b1, 1'b0, 8'h00, 4'b1000, 8'h00, "R10");
        step(4'b1111, 1'b1, 1'b0, 8'h00, 4'b0001, 8'h00, "R10");
        step(4'b1111, 1'b0, 1'b0, 8'h00, 4'b0001, 8'h00, "R7");
        step(4'b1111, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h00, "R10");
        step(4'b0011, 1'b1, 1'b1, 8'h07, 4'b0001, 8'h00, "R2");
        step(4'b0011, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h00, "R10");
        // 24-clock slice
        step(4'b0010, 1'b1, 1'b1, 8'h18, 4'b0010, 8'h18, "R2");
        step(4'b0011, 1'b1, 1'b0, 8'h00, 4'b0001, 8'h18, "R6");
        for (int i = 0; i < 23; i++) step(4'b0011, 1'b1, 1'b0, 8'h00, 4'b0001, 8'h18, "R5");
        step(4'b0011, 1'b1, 1'b0, 8'h00, 4'b0010, 8'h18, "R6");
        wait (exp_g.size() == 0);
        @(posedge clk);
        #3;
        summary();
    end
endmodule